// File: doc/BRIEF.md
# FMA NaN and Special-Case Resolver

This stage sits beside the arithmetic datapath of a single-precision fused multiply-add unit. The same stage serves the multiply-add form (acc + a*b) and the multiply-subtract form (acc - a*b), because both forms follow identical NaN and flag rules. It receives the three binary32 operands (accumulator, multiplicand A, multiplicand B) and a one-bit convention select. It decides whether the result is forced by a NaN operand or by an infinity-times-zero product. When it is, the stage supplies the forced result word and the invalid-operation flag. Otherwise it lowers its special flag, and the normal datapath result is used.

Two conventions are supported. Convention 0 looks for NaNs in the order accumulator, B, A. It quiets a selected signaling NaN and raises invalid for any signaling operand and for infinity times zero. Convention 1 looks in the order A, B, accumulator. It forwards a selected NaN bit for bit and never raises invalid.

The stage has one register. Operands enter through a valid/ready handshake, and the result leaves through a valid/ready handshake. An operand set is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds still and no new input is taken.

Top module: `fmanan_resolver`

## Requirements
- R1: An operand set accepted on an edge appears with `out_valid` high from that edge on. `in_ready` equals `!out_valid || out_ready`. While the output is stalled (`out_valid` high, `out_ready` low), `out_result`, `out_special` and `out_invalid` hold and no input is taken.
- R2: A NaN has exponent 0xFF and a nonzero fraction. It is quiet when fraction bit 22 is 1. Infinity is exponent 0xFF with a zero fraction. Zero is exponent 0 with a zero fraction. Either sign counts in both cases. With no NaN operand and no infinity-times-zero product, `out_special` and `out_invalid` are 0 and `out_result` is 0.
- R3: With `in_mode`=0 and several NaN operands, the result comes from the first NaN in the order accumulator, B, A.
- R4: With `in_mode`=1 and several NaN operands, the result comes from the first NaN in the order A, B, accumulator.
- R5: With `in_mode`=0, a selected signaling NaN is output with bit 22 set and its sign and other bits kept. `out_invalid` is 1 whenever any operand is signaling, selected or not.
- R6: With `in_mode`=1, a selected signaling NaN is output unchanged, and `out_invalid` is always 0.
- R7: Quiet NaN operands alone never raise `out_invalid`. When only quiet NaNs are present, the selected operand is copied unchanged.
- R8: When A*B is infinity times zero (in either order and with any signs) and the accumulator is not a NaN, the result is 0x7FC00000. `out_invalid` is 1 in mode 0 and 0 in mode 1.
- R9: When A*B is infinity times zero and the accumulator is a NaN, the accumulator is the result. Mode 0 quiets it and raises invalid, even for a quiet accumulator. Mode 1 forwards it unchanged with no flag.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Stage can take an operand set |
| in_acc | input | 32 | Accumulator operand |
| in_a | input | 32 | Multiplicand A |
| in_b | input | 32 | Multiplicand B |
| in_mode | input | 1 | NaN convention select (0 or 1) |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result |
| out_special | output | 1 | Result is forced by a special case |
| out_result | output | 32 | Forced result word |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
Uniform random words almost never produce NaNs, infinities or zeros, and they essentially never produce an infinity-zero pair. Because of this, the random stimulus first picks a class for each operand: normal, zero, infinity, quiet NaN, signaling NaN, or raw bits. It then fills in the sign and payload at random, so multi-NaN priority collisions and infinity-times-zero meeting a signaling accumulator occur often. Directed cases pin down each priority order, an unselected signaling operand, negative-sign payloads and the output stall.

// File: rtl/fmanan_pkg.sv
package fmanan_pkg;

  typedef struct packed {
    logic nan;
    logic snan;
    logic inf;
    logic zero;
  } fp_kind_t;

  typedef enum logic {
    NAN_ORDER_ACC_FIRST = 1'b0,
    NAN_ORDER_A_FIRST   = 1'b1
  } nan_conv_e;

  localparam int unsigned N_OPS  = 3;
  localparam int unsigned IDX_ACC = 0;
  localparam int unsigned IDX_A   = 1;
  localparam int unsigned IDX_B   = 2;

endpackage

// File: rtl/fmanan_classify.sv
module fmanan_classify
  import fmanan_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W-1:0] mag,
  output fp_kind_t                kind
);
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic exp_max, exp_zero, frac_zero;

  assign expo      = mag[EXP_W+FRAC_W-1:FRAC_W];
  assign frac      = mag[FRAC_W-1:0];
  assign exp_max   = &expo;
  assign exp_zero  = ~|expo;
  assign frac_zero = ~|frac;

  always_comb begin
    kind.nan  = exp_max & ~frac_zero;
    kind.snan = exp_max & ~frac_zero & ~frac[FRAC_W-1];
    kind.inf  = exp_max & frac_zero;
    kind.zero = exp_zero & frac_zero;
  end
endmodule

// File: rtl/fmanan_pick.sv
module fmanan_pick
  import fmanan_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [N_OPS-1:0][W-1:0] ops,
  input  fp_kind_t [N_OPS-1:0]    kinds,
  input  nan_conv_e               conv,
  output logic                    hit,
  output logic [W-1:0]            word,
  output logic                    word_snan
);
  function automatic logic [1:0] rank_to_idx(nan_conv_e c, int r);
    logic [1:0] idx;
    if (c == NAN_ORDER_ACC_FIRST) begin
      case (r)
        0:       idx = 2'(IDX_ACC);
        1:       idx = 2'(IDX_B);
        default: idx = 2'(IDX_A);
      endcase
    end else begin
      case (r)
        0:       idx = 2'(IDX_A);
        1:       idx = 2'(IDX_B);
        default: idx = 2'(IDX_ACC);
      endcase
    end
    return idx;
  endfunction

  always_comb begin
    hit       = 1'b0;
    word      = '0;
    word_snan = 1'b0;
    for (int r = N_OPS - 1; r >= 0; r--) begin
      logic [1:0] k;
      k = rank_to_idx(conv, r);
      if (kinds[k].nan) begin
        hit       = 1'b1;
        word      = ops[k];
        word_snan = kinds[k].snan;
      end
    end
  end
endmodule

// File: rtl/fmanan_resolver.sv
module fmanan_resolver
  import fmanan_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [EXP_W+FRAC_W:0]       in_acc,
  input  logic [EXP_W+FRAC_W:0]       in_a,
  input  logic [EXP_W+FRAC_W:0]       in_b,
  input  logic                        in_mode,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic                        out_special,
  output logic [EXP_W+FRAC_W:0]       out_result,
  output logic                        out_invalid
);
  localparam int unsigned W    = 1 + EXP_W + FRAC_W;
  localparam int unsigned QBIT = FRAC_W - 1;
  localparam logic [W-1:0] DEFAULT_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] QUIET_MASK = W'(1) << QBIT;

  logic [N_OPS-1:0][W-1:0] ops;
  fp_kind_t [N_OPS-1:0]    kinds;
  nan_conv_e               conv;
  logic                    nan_hit, nan_snan, any_snan, prod_inv;
  logic [W-1:0]            nan_word;
  logic                    nxt_special, nxt_invalid;
  logic [W-1:0]            nxt_result;
  logic                    take;

  assign ops[IDX_ACC] = in_acc;
  assign ops[IDX_A]   = in_a;
  assign ops[IDX_B]   = in_b;
  assign conv         = nan_conv_e'(in_mode);

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fmanan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .mag  (ops[g][W-2:0]),
      .kind (kinds[g])
    );
  end

  fmanan_pick #(.W(W)) u_pick (
    .ops       (ops),
    .kinds     (kinds),
    .conv      (conv),
    .hit       (nan_hit),
    .word      (nan_word),
    .word_snan (nan_snan)
  );

  always_comb begin
    any_snan = 1'b0;
    for (int i = 0; i < N_OPS; i++) any_snan |= kinds[i].snan;
  end

  assign prod_inv = (kinds[IDX_A].inf  & kinds[IDX_B].zero) |
                    (kinds[IDX_A].zero & kinds[IDX_B].inf);

  always_comb begin
    nxt_special = nan_hit | prod_inv;
    nxt_invalid = (conv == NAN_ORDER_ACC_FIRST) & (any_snan | prod_inv);
    if (nan_hit) begin
      if (conv == NAN_ORDER_ACC_FIRST && nan_snan) nxt_result = nan_word | QUIET_MASK;
      else                                         nxt_result = nan_word;
    end else if (prod_inv) begin
      nxt_result = DEFAULT_NAN;
    end else begin
      nxt_result = '0;
    end
  end

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_special <= 1'b0;
      out_invalid <= 1'b0;
      out_result  <= '0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_special <= nxt_special;
        out_invalid <= nxt_invalid;
        out_result  <= nxt_result;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fmanan_resolver_chk.sv
module fmanan_resolver_chk #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  in_mode,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic                  out_special,
  input logic                  out_invalid,
  input logic [EXP_W+FRAC_W:0] out_result
);
  logic mode_q;
  logic res_is_nan, res_quiet;

  always_ff @(posedge clk) begin
    if (!rst_n)                   mode_q <= 1'b0;
    else if (in_valid && in_ready) mode_q <= in_mode;
  end

  assign res_is_nan = (&out_result[EXP_W+FRAC_W-1:FRAC_W]) & (|out_result[FRAC_W-1:0]);
  assign res_quiet  = out_result[FRAC_W-1];

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
                                $stable(out_special) && $stable(out_invalid)); // R1
  AST_INVALID_NEEDS_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_special); // R2
  AST_MODE0_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_special && !mode_q |-> res_is_nan && res_quiet); // R5
  AST_MODE1_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q |-> !out_invalid); // R6
  AST_SPECIAL_IS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_special |-> res_is_nan); // R8
endmodule

bind fmanan_resolver fmanan_resolver_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_mode     (in_mode),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_special (out_special),
  .out_invalid (out_invalid),
  .out_result  (out_result)
);

// File: tb/fmanan_resolver_bench.sv
module fmanan_resolver_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 50000;

  localparam logic [31:0] ONE   = 32'h3F80_0000;
  localparam logic [31:0] PINF  = 32'h7F80_0000;
  localparam logic [31:0] NINF  = 32'hFF80_0000;
  localparam logic [31:0] PZERO = 32'h0000_0000;
  localparam logic [31:0] NZERO = 32'h8000_0000;
  localparam logic [31:0] DNAN  = 32'h7FC0_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_mode = 1'b0;
  logic [31:0] in_acc = '0, in_a = '0, in_b = '0;
  logic out_valid, out_ready = 1'b1, out_special, out_invalid;
  logic [31:0] out_result;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmanan_resolver u_fmanan_resolver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .in_a(in_a), .in_b(in_b), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_special(out_special),
    .out_result(out_result), .out_invalid(out_invalid)
  );

  function automatic logic [31:0] qn(input logic [21:0] p); return 32'h7FC0_0000 | {10'd0, p}; endfunction
  function automatic logic [31:0] sn(input logic [21:0] p); return 32'h7F80_0000 | {10'd0, p}; endfunction
  function automatic bit f_nan(input logic [31:0] x);  return x[30:23] == 8'hFF && x[22:0] != 0; endfunction
  function automatic bit f_snan(input logic [31:0] x); return f_nan(x) && !x[22]; endfunction
  function automatic bit f_inf(input logic [31:0] x);  return x[30:23] == 8'hFF && x[22:0] == 0; endfunction
  function automatic bit f_zero(input logic [31:0] x); return x[30:0] == 0; endfunction

  // returns {special, invalid, result}
  function automatic logic [33:0] model(input logic [31:0] acc, a, b, input logic mode);
    logic [31:0] pickw;
    bit found, infzero, anys;
    pickw = '0; found = 0;
    if (!mode) begin
      if (f_nan(acc))    begin pickw = acc; found = 1; end
      else if (f_nan(b)) begin pickw = b;   found = 1; end
      else if (f_nan(a)) begin pickw = a;   found = 1; end
    end else begin
      if (f_nan(a))        begin pickw = a;   found = 1; end
      else if (f_nan(b))   begin pickw = b;   found = 1; end
      else if (f_nan(acc)) begin pickw = acc; found = 1; end
    end
    infzero = (f_inf(a) && f_zero(b)) || (f_zero(a) && f_inf(b));
    anys    = f_snan(acc) || f_snan(a) || f_snan(b);
    if (found)        return {1'b1, !mode && (anys || infzero), mode ? pickw : (pickw | 32'h0040_0000)};
    else if (infzero) return {1'b1, !mode, DNAN};
    else              return {2'b00, 32'h0};
  endfunction

  task automatic check(input string tag, input bit ok, input logic [33:0] act, input logic [33:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual special=%0b invalid=%0b result=%08h, expected special=%0b invalid=%0b result=%08h",
               tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic send(input string tag, input logic [31:0] acc, a, b, input logic mode);
    logic [33:0] e, g;
    @(negedge clk);
    in_acc = acc; in_a = a; in_b = b; in_mode = mode; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    e = model(acc, a, b, mode);
    g = {out_special, out_invalid, out_result};
    check(tag, out_valid && g == e, g, e);
  endtask

  function automatic logic [31:0] rnd_op();
    logic [31:0] r;
    r = $urandom;
    case ($urandom_range(0, 5))
      0: return {r[31], 8'($urandom_range(1, 254)), r[22:0]};
      1: return {r[31], 31'h0};
      2: return {r[31], 8'hFF, 23'h0};
      3: return {r[31], 8'hFF, 1'b1, r[21:0]};
      4: return {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
      default: return r;
    endcase
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > MAX_CYCLES) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, MAX_CYCLES);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset", !out_valid && in_ready, {out_valid, in_ready, 32'h0}, {2'b01, 32'h0});

    // R2: ordinary operands leave special low
    send("R2 normal m0", ONE, ONE, ONE, 1'b0);
    send("R2 normal m1", ONE, ONE, ONE, 1'b1);
    send("R2 inf acc", PINF, ONE, PZERO, 1'b0);
    send("R2 inf*one", ONE, NINF, ONE, 1'b0);
    // R3: mode 0 priority acc, B, A
    send("R3 all nan", qn(1), qn(2), qn(3), 1'b0);
    send("R3 A and B", ONE, qn(2), qn(3), 1'b0);
    send("R3 A only", ONE, qn(2), ONE, 1'b0);
    // R4: mode 1 priority A, B, acc
    send("R4 all nan", qn(1), qn(2), qn(3), 1'b1);
    send("R4 acc and B", qn(1), ONE, qn(3), 1'b1);
    send("R4 acc only", qn(1), ONE, ONE, 1'b1);
    // R5: quieting and invalid from any signaling operand
    send("R5 snan acc", sn(1), ONE, ONE, 1'b0);
    send("R5 neg snan", 32'hFF80_0003, ONE, ONE, 1'b0);
    send("R5 unselected snan", qn(1), sn(5), ONE, 1'b0);
    // R6: mode 1 forwards signaling NaN silently
    send("R6 snan acc", sn(1), ONE, ONE, 1'b1);
    send("R6 snan A wins", qn(1), sn(5), ONE, 1'b1);
    // R7: quiet NaNs copied, no invalid
    send("R7 neg qnan", ONE, ONE, 32'hFFC1_2345, 1'b0);
    send("R7 neg qnan m1", ONE, ONE, 32'hFFC1_2345, 1'b1);
    // R8: inf*zero with non-NaN accumulator
    send("R8 inf*0 m0", ONE, PINF, PZERO, 1'b0);
    send("R8 inf*0 m1", ONE, PINF, PZERO, 1'b1);
    send("R8 -0*-inf m0", NINF, NZERO, NINF, 1'b0);
    // R9: inf*zero with NaN accumulator
    send("R9 snan acc m0", sn(1), PINF, PZERO, 1'b0);
    send("R9 snan acc m1", sn(1), PINF, PZERO, 1'b1);
    send("R9 qnan acc m0", qn(1), PZERO, PINF, 1'b0);
    send("R9 qnan acc m1", qn(1), PZERO, PINF, 1'b1);

    // R1: stall holds the output and blocks input
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    in_acc = qn(7); in_a = ONE; in_b = ONE; in_mode = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_acc = qn(9);
    check("R1 stalled first", out_valid && !in_ready && out_result == qn(7),
          {out_valid, in_ready, out_result}, {2'b10, qn(7)});
    @(negedge clk);
    check("R1 still held", out_valid && !in_ready && out_result == qn(7),
          {out_valid, in_ready, out_result}, {2'b10, qn(7)});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 next after drain", out_valid && out_result == qn(9),
          {out_valid, in_ready, out_result}, {2'b11, qn(9)});

    // random mix with class-biased operands
    for (int i = 0; i < 600; i++) begin
      logic m;
      m = 1'($urandom_range(0, 1));
      send(m ? "R4 random" : "R3 random", rnd_op(), rnd_op(), rnd_op(), m);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule